// File: doc/BRIEF.md
# Serial Rate Detector and Lock Monitor

This block decides which serial video rate is arriving by counting rising edges of a prescaled copy of the serial clock over a window of fixed length, timed by a 27 MHz reference. At the end of each window the count is checked against a band of ±1% around the count expected for each supported rate. The supported rates are 143 Mbps, 270 Mbps and the high-definition class (1483 and 1485 Mbps, which share one band). The result drives a lock flag, a rate code, an SD/HD indicator and a flag that asks the downstream reclocker to bypass.

The prescaled clock enters as a plain input. It passes through a synchronizer in the reference domain, so the prescale ratio must hold its frequency below half the reference rate. A two-bit selection input picks one of three modes: free detection of every supported rate, or a single forced rate. A rate that is not allowed by the current mode is handled like an unknown rate. Lock needs two windows in a row that agree on the same rate. With the default window of 131072 reference cycles, acquisition takes about 10 ms.

Top module: `rate_lock_mon`

## Requirements
- R1: While rst_ni is low, lock_o, rate_o, sd_hd_o and unsup_o are all 0.
- R2: rate_o encodes the locked rate as 2'b01 for 143 Mbps, 2'b10 for 270 Mbps and 2'b11 for the 1483/1485 class. It is 2'b00 whenever lock_o is low. In automatic mode a steady 270 Mbps input locks with rate_o = 2'b10.
- R3: In automatic mode, 1483 Mbps and 1485 Mbps inputs both lock with rate_o = 2'b11 and sd_hd_o = 0.
- R4: 143 Mbps locks only in automatic detection (rate_sel_i 2'b00 or 2'b11). Under either forced code the same input gives lock_o = 0 and unsup_o = 1.
- R5: With rate_sel_i = 2'b01, only 270 Mbps locks. A 1485 Mbps input gives lock_o = 0 and unsup_o = 1.
- R6: With rate_sel_i = 2'b10, only the 1483/1485 class locks. A 270 Mbps input gives lock_o = 0 and unsup_o = 1.
- R7: Inputs at 177, 360 and 540 Mbps never lock and raise unsup_o.
- R8: Harmonic or sub-harmonic relatives of supported rates (286 Mbps, 742 Mbps) never lock and raise unsup_o.
- R9: sd_hd_o is registered. It is 1 only while locked to 143 or 270 Mbps. It is 0 while locked to the HD class and 0 whenever lock_o is low.
- R10: Outputs change only at the end of a window. Lock asserts only after two consecutive windows classify the same allowed rate. A single failing window clears it.
- R11: A window with zero edges (no data) gives lock_o = 0, rate_o = 2'b00 and unsup_o = 0.
- R12: The reserved code rate_sel_i = 2'b11 behaves as automatic detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | 27 MHz reference clock, clocks all logic |
| rst_ni | input | 1 | Active-low asynchronous reset |
| meas_clk_i | input | 1 | Prescaled serial clock under measurement |
| rate_sel_i | input | 2 | 00/11 automatic, 01 force 270 Mbps, 10 force HD class |
| lock_o | output | 1 | Rate locked |
| rate_o | output | 2 | Locked rate code, 00 when unlocked |
| sd_hd_o | output | 1 | 1 for SD rates, 0 for HD or unlocked |
| unsup_o | output | 1 | Edges present but no allowed rate matched; requests bypass |

## Verification
The hardest state to reach is the window in which lock is still pending: the first window has matched, but no second window has confirmed it. Reaching it needs a known window phase. The bench applies a clean 270 Mbps clock before reset is released, so window boundaries fall at multiples of the window length. It then samples halfway through the second window, and again after the second window has ended. Loss of lock after a single failing window is reached the same way, by switching a locked input to an unsupported rate and sampling after exactly one complete bad window.

// File: rtl/rlm_pkg.sv
`timescale 1ns/1ps
package rlm_pkg;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'b00,
    CLS_SD_LO = 2'b01,
    CLS_SD    = 2'b10,
    CLS_HD    = 2'b11
  } rate_cls_e;

  localparam int unsigned NUM_BANDS = 3;
  localparam int unsigned TOL_PCT   = 1;

  // band centre in units of 0.1 Mbps; HD band centred between 1483 and 1485
  function automatic int unsigned band_rate_x10(int unsigned b);
    case (b)
      0:       return 1430;
      1:       return 2700;
      default: return 14840;
    endcase
  endfunction

  // expected edge count bound for a window of win reference cycles at 27 MHz
  function automatic longint unsigned band_bound(int unsigned rate_x10, int unsigned win,
                                                 int unsigned presc, bit upper);
    longint unsigned num, den;
    den = longint'(27) * longint'(presc) * 64'd1000;
    num = longint'(win) * longint'(rate_x10);
    if (upper) return (num * (100 + TOL_PCT) + den - 1) / den;
    return (num * (100 - TOL_PCT)) / den;
  endfunction

  function automatic logic band_allowed(logic [1:0] sel, int unsigned b);
    case (sel)
      2'b01:   return b == 1;
      2'b10:   return b == 2;
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/rlm_edge_det.sv
`timescale 1ns/1ps
module rlm_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], sig_i};
  end

  assign rise_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/rlm_win_cnt.sv
`timescale 1ns/1ps
module rlm_win_cnt #(
  parameter int unsigned WIN_LEN = 131072,
  parameter int unsigned CNT_W   = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_i,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int unsigned WIN_W = $clog2(WIN_LEN);

  logic [WIN_W-1:0] tick_q;
  logic [CNT_W-1:0] acc_q;
  logic             last;

  assign last = (tick_q == WIN_W'(WIN_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      acc_q  <= '0;
      cnt_o  <= '0;
      done_o <= 1'b0;
    end else if (last) begin
      tick_q <= '0;
      acc_q  <= '0;
      cnt_o  <= acc_q + CNT_W'(edge_i);
      done_o <= 1'b1;
    end else begin
      tick_q <= tick_q + 1'b1;
      acc_q  <= acc_q + CNT_W'(edge_i);
      done_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rlm_classify.sv
`timescale 1ns/1ps
module rlm_classify
  import rlm_pkg::*;
#(
  parameter int unsigned WIN_LEN  = 131072,
  parameter int unsigned PRESCALE = 128,
  parameter int unsigned CNT_W    = 18
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [1:0]       sel_i,
  output rate_cls_e        cls_o
);
  logic [NUM_BANDS-1:0] hit;

  for (genvar b = 0; b < NUM_BANDS; b++) begin : g_band
    localparam longint unsigned LO = band_bound(band_rate_x10(b), WIN_LEN, PRESCALE, 1'b0);
    localparam longint unsigned HI = band_bound(band_rate_x10(b), WIN_LEN, PRESCALE, 1'b1);
    assign hit[b] = (64'(cnt_i) >= LO) && (64'(cnt_i) <= HI) && band_allowed(sel_i, b);
  end

  always_comb begin
    cls_o = CLS_NONE;
    for (int b = 0; b < NUM_BANDS; b++)
      if (hit[b]) cls_o = rate_cls_e'(2'(b + 1));
  end
endmodule

// File: rtl/rlm_lock_trk.sv
`timescale 1ns/1ps
module rlm_lock_trk
  import rlm_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      done_i,
  input  logic      data_i,
  input  rate_cls_e cls_i,
  output logic      lock_o,
  output logic [1:0] rate_o,
  output logic      sd_hd_o,
  output logic      unsup_o
);
  rate_cls_e prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= CLS_NONE;
      lock_o  <= 1'b0;
      rate_o  <= 2'b00;
      sd_hd_o <= 1'b0;
      unsup_o <= 1'b0;
    end else if (done_i) begin
      prev_q  <= cls_i;
      unsup_o <= data_i && (cls_i == CLS_NONE);
      if (cls_i != CLS_NONE && cls_i == prev_q) begin
        lock_o  <= 1'b1;
        rate_o  <= cls_i;
        sd_hd_o <= (cls_i != CLS_HD);
      end else begin
        lock_o  <= 1'b0;
        rate_o  <= 2'b00;
        sd_hd_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rate_lock_mon.sv
`timescale 1ns/1ps
module rate_lock_mon
  import rlm_pkg::*;
#(
  parameter int unsigned WIN_LEN     = 131072,
  parameter int unsigned PRESCALE    = 128,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       ref_clk_i,
  input  logic       rst_ni,
  input  logic       meas_clk_i,
  input  logic [1:0] rate_sel_i,
  output logic       lock_o,
  output logic [1:0] rate_o,
  output logic       sd_hd_o,
  output logic       unsup_o
);
  localparam int unsigned CNT_W = $clog2(WIN_LEN + 1);

  logic [1:0]       sel_s1_q, sel_q;
  logic             meas_rise;
  logic             win_done;
  logic [CNT_W-1:0] win_cnt;
  rate_cls_e        cls;

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_s1_q <= 2'b00;
      sel_q    <= 2'b00;
    end else begin
      sel_s1_q <= rate_sel_i;
      sel_q    <= sel_s1_q;
    end
  end

  rlm_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i (ref_clk_i),
    .rst_ni(rst_ni),
    .sig_i (meas_clk_i),
    .rise_o(meas_rise)
  );

  rlm_win_cnt #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) u_win (
    .clk_i (ref_clk_i),
    .rst_ni(rst_ni),
    .edge_i(meas_rise),
    .done_o(win_done),
    .cnt_o (win_cnt)
  );

  rlm_classify #(.WIN_LEN(WIN_LEN), .PRESCALE(PRESCALE), .CNT_W(CNT_W)) u_cls (
    .cnt_i(win_cnt),
    .sel_i(sel_q),
    .cls_o(cls)
  );

  rlm_lock_trk u_trk (
    .clk_i  (ref_clk_i),
    .rst_ni (rst_ni),
    .done_i (win_done),
    .data_i (win_cnt != '0),
    .cls_i  (cls),
    .lock_o (lock_o),
    .rate_o (rate_o),
    .sd_hd_o(sd_hd_o),
    .unsup_o(unsup_o)
  );
endmodule

// File: rtl/rlm_chk.sv
`timescale 1ns/1ps
module rlm_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       win_done_i,
  input logic       lock_i,
  input logic [1:0] rate_i,
  input logic       sd_hd_i,
  input logic       unsup_i
);
  // R9
  sd_needs_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_hd_i |-> lock_i);

  // R9
  sd_matches_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |-> (sd_hd_i == (rate_i != 2'b11)));

  // R2
  rate_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i == (rate_i != 2'b00));

  // R7
  unsup_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unsup_i |-> !lock_i);

  // R10
  hold_between_windows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_done_i |=> $stable({lock_i, rate_i, sd_hd_i, unsup_i}));

  // R10
  lock_rise_at_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_i) |-> $past(win_done_i));
endmodule

bind rate_lock_mon rlm_chk u_rlm_chk (
  .clk_i     (ref_clk_i),
  .rst_ni    (rst_ni),
  .win_done_i(win_done),
  .lock_i    (lock_o),
  .rate_i    (rate_o),
  .sd_hd_i   (sd_hd_o),
  .unsup_i   (unsup_o)
);

// File: tb/tb_rate_lock_mon.sv
`timescale 1ns/1ps
module tb_rate_lock_mon;
  localparam real CLK_PERIOD = 10.0;
  localparam int  WIN        = 2048;
  localparam int  PRESC      = 128;
  localparam int  WAIT_CYC   = 3 * WIN + 20;

  logic       ref_clk = 1'b0;
  logic       meas_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rate_sel = 2'b00;
  logic       lock, sd_hd, unsup;
  logic [1:0] rate;

  real meas_half = 1000.0;
  bit  meas_run  = 1'b0;
  int  n_vec = 0, n_bad = 0;
  bit  finished = 1'b0;

  typedef struct packed {
    logic       lk;
    logic [1:0] rt;
    logic       sd;
    logic       us;
  } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  rate_lock_mon #(.WIN_LEN(WIN), .PRESCALE(PRESC)) dut (
    .ref_clk_i (ref_clk),
    .rst_ni    (rst_n),
    .meas_clk_i(meas_clk),
    .rate_sel_i(rate_sel),
    .lock_o    (lock),
    .rate_o    (rate),
    .sd_hd_o   (sd_hd),
    .unsup_o   (unsup)
  );

  always #(CLK_PERIOD / 2.0) ref_clk = ~ref_clk;

  initial forever begin
    if (meas_run) begin
      #(meas_half);
      meas_clk = ~meas_clk;
    end else begin
      meas_clk = 1'b0;
      #(CLK_PERIOD);
    end
  end

  task automatic set_rate(real mbps);
    if (mbps == 0.0) meas_run = 1'b0;
    else begin
      meas_half = CLK_PERIOD * 27.0 * PRESC / (2.0 * mbps);
      meas_run  = 1'b1;
    end
  endtask

  task automatic cmp(string tag, string fld, int act, int expv);
    n_vec++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, fld, act, expv);
    end
  endtask

  // monitor: pops expected items and compares against the ports
  initial forever begin
    exp_t e;
    string t;
    wait (exp_q.size() != 0);
    @(negedge ref_clk);
    e = exp_q[0];
    t = tag_q[0];
    cmp(t, "lock",  int'(lock),  int'(e.lk));
    cmp(t, "rate",  int'(rate),  int'(e.rt));
    cmp(t, "sd_hd", int'(sd_hd), int'(e.sd));
    cmp(t, "unsup", int'(unsup), int'(e.us));
    void'(tag_q.pop_front());
    void'(exp_q.pop_front());
  end

  task automatic expect_out(string tag, logic lk, logic [1:0] rt, logic sd, logic us);
    exp_t e;
    e = '{lk: lk, rt: rt, sd: sd, us: us};
    exp_q.push_back(e);
    tag_q.push_back(tag);
    wait (exp_q.size() == 0);
    @(negedge ref_clk);
  endtask

  task automatic run(real mbps, logic [1:0] sel, string tag,
                     logic lk, logic [1:0] rt, logic sd, logic us);
    set_rate(mbps);
    rate_sel = sel;
    repeat (WAIT_CYC) @(negedge ref_clk);
    expect_out(tag, lk, rt, sd, us);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge ref_clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    set_rate(270.0);
    rate_sel = 2'b00;
    repeat (5) @(negedge ref_clk);
    expect_out("R1 reset", 1'b0, 2'b00, 1'b0, 1'b0);
    rst_n = 1'b1;
    // R10: one window matched, second pending -> still unlocked
    repeat (WIN + WIN / 2) @(negedge ref_clk);
    expect_out("R10 single window", 1'b0, 2'b00, 1'b0, 1'b0);
    repeat (WIN) @(negedge ref_clk);
    expect_out("R10 R2 two windows 270", 1'b1, 2'b10, 1'b1, 1'b0);

    run(1485.0, 2'b00, "R3 auto 1485",  1'b1, 2'b11, 1'b0, 1'b0);
    run(1483.0, 2'b00, "R3 auto 1483",  1'b1, 2'b11, 1'b0, 1'b0);
    run(143.0,  2'b00, "R4 auto 143",   1'b1, 2'b01, 1'b1, 1'b0);
    run(177.0,  2'b00, "R7 177",        1'b0, 2'b00, 1'b0, 1'b1);
    run(360.0,  2'b00, "R7 360",        1'b0, 2'b00, 1'b0, 1'b1);
    run(540.0,  2'b00, "R7 540",        1'b0, 2'b00, 1'b0, 1'b1);
    run(286.0,  2'b00, "R8 286",        1'b0, 2'b00, 1'b0, 1'b1);
    run(742.0,  2'b00, "R8 742",        1'b0, 2'b00, 1'b0, 1'b1);
    run(0.0,    2'b00, "R11 no data",   1'b0, 2'b00, 1'b0, 1'b0);
    run(270.0,  2'b01, "R5 forced 270", 1'b1, 2'b10, 1'b1, 1'b0);
    run(1485.0, 2'b01, "R5 forced 270 hd in", 1'b0, 2'b00, 1'b0, 1'b1);
    run(143.0,  2'b01, "R4 forced 270 143 in", 1'b0, 2'b00, 1'b0, 1'b1);
    run(1485.0, 2'b10, "R6 forced hd",  1'b1, 2'b11, 1'b0, 1'b0);
    run(270.0,  2'b10, "R6 forced hd 270 in", 1'b0, 2'b00, 1'b0, 1'b1);
    run(143.0,  2'b10, "R4 forced hd 143 in", 1'b0, 2'b00, 1'b0, 1'b1);
    run(143.0,  2'b11, "R12 reserved 143", 1'b1, 2'b01, 1'b1, 1'b0);
    run(1485.0, 2'b11, "R12 reserved 1485 R9", 1'b1, 2'b11, 1'b0, 1'b0);
    run(270.0,  2'b00, "R2 relock 270", 1'b1, 2'b10, 1'b1, 1'b0);

    // R10: a single failing window drops lock
    set_rate(177.0);
    repeat (2 * WIN + 20) @(negedge ref_clk);
    expect_out("R10 R9 drop on one bad window", 1'b0, 2'b00, 1'b0, 1'b1);

    summary();
  end
endmodule